// File: doc/BRIEF.md
# Section Descriptor Table Walker

This block turns a 32-bit virtual address into a physical address by reading one descriptor from a single-level table in memory. Each descriptor covers a 1 MB section. There are 4096 descriptors of 4 bytes each, so the table takes 16 KB. The top 12 address bits pick the descriptor. The low 20 bits pass straight through as the offset inside the section.

A requester hands over a virtual address with a valid/ready handshake. At that moment the block also samples the table base register value. It builds the descriptor address and issues one word read on a simple request/response memory port. It then decodes the returned word. A section descriptor yields the physical address and the attribute fields. A fault descriptor, or one that points to a second-level table, yields a fault code with zeroed address and attributes.

The result is held until the requester acknowledges it. The domain and access fields are only passed on to a separate protection checker. No permission decision is made here, and only one walk is in flight at a time.

Top module: `section_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: The cycle after a request is accepted, `mem_req_valid` is 1. `mem_req_addr` is then {table base bits [31:14], virtual address bits [31:20], 2'b00}.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request and its address stay unchanged.
- R4: A descriptor with bits [1:0] = 2'b10 is a section. For it, `res_paddr` = {descriptor [31:20], virtual address [19:0]} and `res_fault` = 2'b00.
- R5: For a section, the outputs take their values from the descriptor as follows:
  - `res_domain` = descriptor [8:5]
  - `res_ap` = descriptor [11:10]
  - `res_c` = descriptor [3]
  - `res_b` = descriptor [2]
- R6: A descriptor with bits [1:0] = 2'b00 gives `res_fault` = 2'b01. In that case the address and all attribute outputs are 0.
- R7: A descriptor with bits [1:0] = 2'b01 or 2'b11 is a second-level kind. It gives `res_fault` = 2'b10, with the address and all attribute outputs 0.
- R8: From the accepting edge until the result is acknowledged, `req_ready` is 0. No second walk starts in that time.
- R9: The result appears the cycle after the response is taken. It stays stable while `res_ack` is 0. The cycle after it is acknowledged, `res_valid` is 0 and `req_ready` is 1.
- R10: Changes on `req_vaddr` and `tbl_base` after acceptance have no effect on the walk in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Table base register value (16 KB aligned use) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result present |
| res_ack | input | 1 | Requester consumes the result |
| res_paddr | output | 32 | Physical address |
| res_domain | output | 4 | Domain field for the checker |
| res_ap | output | 2 | Access permission field |
| res_c | output | 1 | Cacheable bit |
| res_b | output | 1 | Bufferable bit |
| res_fault | output | 2 | 00 none, 01 translation fault, 10 unsupported walk |

## Verification
The hardest case is a walk in which the inputs the walker sampled change while it is still waiting on memory. If the design read the live inputs, it would fetch the wrong word or splice in the wrong offset. To reach that case, the bench scrambles `req_vaddr` and `tbl_base` to fresh random values on the first cycle after acceptance. It then stretches the walk with random grant, response and acknowledge delays. This keeps the stale and fresh values apart for many cycles before the descriptor arrives and the result is compared.

// File: rtl/section_walker.sv
module section_walker #(
  parameter int AW    = 32,
  parameter int IDX_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] tbl_base,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ack,
  output logic [AW-1:0] res_paddr,
  output logic [3:0]    res_domain,
  output logic [1:0]    res_ap,
  output logic          res_c,
  output logic          res_b,
  output logic [1:0]    res_fault
);
  localparam int OFF_W  = AW - IDX_W;
  localparam int BASE_W = AW - IDX_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} state_t;
  state_t state;

  logic [OFF_W-1:0] off_q;
  logic [AW-1:0]    addr_q, desc_q;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign res_valid     = (state == S_DONE);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      off_q  <= '0;
      addr_q <= '0;
      desc_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          off_q  <= req_vaddr[OFF_W-1:0];
          addr_q <= {tbl_base[AW-1:AW-BASE_W], req_vaddr[AW-1:OFF_W], 2'b00};
          state  <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          state  <= S_DONE;
        end
        S_DONE: if (res_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic is_sec;
  assign is_sec     = (desc_q[1:0] == 2'b10);
  assign res_fault  = (desc_q[1:0] == 2'b00) ? 2'b01 : (is_sec ? 2'b00 : 2'b10);
  assign res_paddr  = is_sec ? {desc_q[AW-1:OFF_W], off_q} : '0;
  assign res_domain = is_sec ? desc_q[8:5]   : 4'd0;
  assign res_ap     = is_sec ? desc_q[11:10] : 2'd0;
  assign res_c      = is_sec & desc_q[3];
  assign res_b      = is_sec & desc_q[2];

  // R2
  p_fetch_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid && mem_req_addr[1:0] == 2'b00);
  // R3
  p_fetch_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R6, R7
  p_fault_zeroed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'b00 |-> res_paddr == '0 && res_domain == 4'd0 && res_ap == 2'd0);
  // R8
  p_single_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, mem_req_valid, res_valid}) <= 1);
  // R9
  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ack |=> res_valid && $stable(res_paddr) && $stable(res_fault)
      && $stable(res_domain) && $stable(res_ap));
  // R9
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ack |=> req_ready && !res_valid);
endmodule

// File: tb/tb_section_walker.sv
module tb_section_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0, res_ack = 0;
  logic [31:0] req_vaddr = 0, tbl_base = 0, mem_rsp_data = 0;
  logic req_ready, mem_req_valid, res_valid, res_c, res_b;
  logic [31:0] mem_req_addr, res_paddr;
  logic [3:0] res_domain;
  logic [1:0] res_ap, res_fault;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  section_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ack(res_ack), .res_paddr(res_paddr),
    .res_domain(res_domain), .res_ap(res_ap), .res_c(res_c), .res_b(res_b),
    .res_fault(res_fault));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: act=%0d exp<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] e_fault(input logic [31:0] d);
    return d[1:0] == 2'b00 ? 2'b01 : (d[1:0] == 2'b10 ? 2'b00 : 2'b10);
  endfunction
  function automatic logic [31:0] e_paddr(input logic [31:0] d, input logic [31:0] va);
    return d[1:0] == 2'b10 ? {d[31:20], va[19:0]} : 32'h0;
  endfunction
  function automatic logic [7:0] e_attr(input logic [31:0] d);
    return d[1:0] == 2'b10 ? {d[8:5], d[11:10], d[3], d[2]} : 8'h0;
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [31:0] desc,
                      input int gnt_dly, input int rsp_dly, input int ack_dly);
    logic [31:0] exp_addr;
    logic [7:0] attr;
    exp_addr = {base[31:14], va[31:20], 2'b00};
    req_valid = 1; req_vaddr = va; tbl_base = base;
    chk(req_ready === 1'b1, "R8 ready before walk", {31'b0, req_ready}, 32'h1);
    step();
    req_valid = 0;
    req_vaddr = $urandom; tbl_base = $urandom; // R10: scramble after acceptance
    chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R2 R10 fetch addr", mem_req_addr, exp_addr);
    chk(req_ready === 1'b0, "R8 busy after accept", {31'b0, req_ready}, 32'h0);
    for (int i = 0; i < gnt_dly; i++) begin
      step();
      chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R3 request held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1;
    step();
    mem_req_ready = 0;
    chk(mem_req_valid === 1'b0, "R3 request dropped after grant", {31'b0, mem_req_valid}, 32'h0);
    for (int i = 0; i < rsp_dly; i++) begin
      step();
      chk(res_valid === 1'b0 && req_ready === 1'b0, "R8 no result while waiting", {30'b0, res_valid, req_ready}, 32'h0);
    end
    mem_rsp_valid = 1; mem_rsp_data = desc;
    step();
    mem_rsp_valid = 0; mem_rsp_data = $urandom;
    attr = e_attr(desc);
    for (int i = 0; i <= ack_dly; i++) begin
      chk(res_valid === 1'b1, "R9 result valid", {31'b0, res_valid}, 32'h1);
      chk(res_paddr === e_paddr(desc, va), desc[1:0] == 2'b10 ? "R4 paddr" : "R6 R7 paddr zero",
          res_paddr, e_paddr(desc, va));
      chk(res_fault === e_fault(desc), desc[1:0] == 2'b00 ? "R6 fault code" : "R7 R4 fault code",
          {30'b0, res_fault}, {30'b0, e_fault(desc)});
      chk({res_domain, res_ap, res_c, res_b} === attr, "R5 attributes",
          {24'b0, res_domain, res_ap, res_c, res_b}, {24'b0, attr});
      if (i < ack_dly) step();
    end
    res_ack = 1;
    step();
    res_ack = 0;
    chk(res_valid === 1'b0 && req_ready === 1'b1, "R9 release", {30'b0, res_valid, req_ready}, 32'h1);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'h1);
    chk(mem_req_valid === 1'b0 && res_valid === 1'b0, "R1 reset idle", {30'b0, mem_req_valid, res_valid}, 32'h0);
    walk(32'h3000_0012, 32'h3000_4000, 32'h3000_0C0E, 0, 0, 0);
    walk(32'hFFFA_BCDE, 32'h1234_7FFF, 32'hABC0_0556, 2, 3, 2);
    walk(32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFC, 1, 0, 1);
    walk(32'h8765_4321, 32'hC000_0000, 32'h1234_5671, 0, 2, 0);
    walk(32'h0010_0004, 32'h4000_C000, 32'hFFFF_FFFF, 3, 1, 3);
    for (int n = 0; n < 60; n++) begin
      d = $urandom;
      walk($urandom, $urandom, d, $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 3));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule